// File: doc/BRIEF.md
# NAND Sector SEC-DED Engine

This block protects one sector of NAND page data with a single-error-correcting, double-error-detecting parity code. The sector streams through it one byte per valid cycle, and the block keeps a running parity accumulation as the bytes go by. In write mode it hands out the finished code one cycle after the last byte, so that the controller can place it in the spare area. In read mode the stored code comes in alongside the last byte. The block compares it with the recomputed code and decodes the difference (the syndrome).

A single flipped data bit is repaired without any software step. One cycle after the last byte, the block issues a read-modify-write to the sector buffer: a byte address and a one-hot XOR mask. The result of each read is packed into a 4-bit status word with one field for the main (data) region and one for the spare (code) region. A field value of 2 flags an uncorrectable sector. A global enable turns the whole function off. While it is low, no code is produced, no correction is issued and the status reads zero.

Top module: `nand_secded_engine`

## Requirements
- R1: The code has 2*(log2(SECTOR_BYTES)+3) bits (24 for 512-byte sectors). For every set data bit at byte index i (arrival order, from 0) and bit position b, code bit 2*j+b[j] toggles for j in 0..2, and code bit 6+2*k+i[k] toggles for each index bit k.
- R2: In write mode `ecc_vld` is high for exactly the cycle after the last byte, with `ecc_code` equal to the code of the sector. A write sector leaves `status` unchanged.
- R3: In read mode, if the syndrome (recomputed XOR stored) holds exactly one set bit in every even/odd pair, `fix_we` is high in the cycle after the last byte. In that cycle `fix_addr` carries the odd row bits (the byte index) and `fix_mask` is one-hot at the bit position given by the odd column bits.
- R4: A read sector whose syndrome is zero issues no correction and leaves both status fields at 0.
- R5: A syndrome with exactly one bit set means an error in the stored code only. The data is not corrected, the main field is 0 and the spare field is 1.
- R6: Any other nonzero syndrome, for example two flipped data bits, issues no correction and sets the main field to 2.
- R7: `status[1:0]` is the main field and `status[3:2]` the spare field. The codes are 0 for clean, 1 for repaired and 2 for uncorrectable. The fields update on the clock edge after the correction cycle and hold until the next read sector completes.
- R8: While `ecc_en` is low, `ecc_vld` and `fix_we` stay low and `status` is 0 from the next edge on.
- R9: After reset, `ecc_vld`, `fix_we` and `status` are 0.
- R10: Sectors may follow back to back with no idle cycle. Accumulation restarts at byte 0 of each sector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ecc_en | input | 1 | Enables code generation, checking and correction |
| rd_mode | input | 1 | 1 selects the check path, 0 the generate path; sampled with each byte |
| in_vld | input | 1 | A sector byte is present on `in_byte` |
| in_byte | input | 8 | Sector data byte |
| stored_ecc | input | 2*(log2(SECTOR_BYTES)+3) | Code read from the spare area; must be valid with the last byte |
| ecc_vld | output | 1 | Generated code valid (write mode) |
| ecc_code | output | 2*(log2(SECTOR_BYTES)+3) | Generated code |
| fix_we | output | 1 | Buffer read-modify-write strobe |
| fix_addr | output | log2(SECTOR_BYTES) | Byte index to repair |
| fix_mask | output | 8 | XOR mask for the repaired byte |
| status | output | 4 | Packed status: main in [1:0], spare in [3:2] |

## Verification
The bench flips every data bit of a 32-byte sector one at a time and requires the exact byte and bit to be repaired. A design with swapped pair polarity or mis-mapped index bits would write the wrong byte and leave the error in place. Each bit of the stored code is also corrupted alone. A design that treats these as data errors would damage a clean byte instead of reporting a spare-region fault. Pairs of data-bit errors, including pairs whose combined syndrome carries many set bits, must come out uncorrectable. A decoder that only counts set bits would miscorrect some of them. Back-to-back sectors, status holding across a write sector, and the disabled mode catch stale accumulation and status leaking past the enable.

// File: rtl/secded_pkg.sv
package secded_pkg;

    localparam int BYTE_W   = 8;
    localparam int COL_BITS = 3;

    typedef enum logic [1:0] {
        SEC_CLEAN = 2'd0,
        SEC_FIXED = 2'd1,
        SEC_FAIL  = 2'd2
    } sec_stat_e;

    // Packed so that the main field lands in bits [1:0], spare in [3:2].
    typedef struct packed {
        sec_stat_e spare;
        sec_stat_e main;
    } sec_status_t;

    // Column parity pairs of one byte: pair j splits the bit positions by bit j.
    function automatic logic [2*COL_BITS-1:0] col_parity(input logic [BYTE_W-1:0] d);
        logic [2*COL_BITS-1:0] r;
        r = '0;
        for (int b = 0; b < BYTE_W; b++) begin
            for (int j = 0; j < COL_BITS; j++) begin
                if (b[j]) r[2*j+1] = r[2*j+1] ^ d[b];
                else      r[2*j]   = r[2*j]   ^ d[b];
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/secded_accum.sv
module secded_accum
    import secded_pkg::*;
#(
    parameter int SECTOR_BYTES = 512
) (
    input  logic                                          clk,
    input  logic                                          rst,
    input  logic                                          in_vld,
    input  logic [BYTE_W-1:0]                             in_byte,
    output logic [2*($clog2(SECTOR_BYTES)+COL_BITS)-1:0]  acc,
    output logic                                          done
);
    localparam int ROW_BITS = $clog2(SECTOR_BYTES);
    localparam int ECC_BITS = 2 * (ROW_BITS + COL_BITS);
    localparam logic [ROW_BITS-1:0] LAST_IDX = ROW_BITS'(SECTOR_BYTES - 1);

    logic [ROW_BITS-1:0] idx;
    logic [ECC_BITS-1:0] contrib;
    logic                bytepar;

    assign bytepar = ^in_byte;
    assign contrib[2*COL_BITS-1:0] = col_parity(in_byte);

    for (genvar k = 0; k < ROW_BITS; k++) begin : g_row
        assign contrib[2*COL_BITS+2*k]   = bytepar & ~idx[k];
        assign contrib[2*COL_BITS+2*k+1] = bytepar &  idx[k];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx  <= '0;
            acc  <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (in_vld) begin
                idx  <= idx + 1'b1;
                acc  <= ((idx == '0) ? '0 : acc) ^ contrib;
                done <= (idx == LAST_IDX);
            end
        end
    end

endmodule

// File: rtl/secded_decode.sv
module secded_decode
    import secded_pkg::*;
#(
    parameter int ROW_BITS = 9
) (
    input  logic [2*(ROW_BITS+COL_BITS)-1:0] syn,
    output logic                             correctable,
    output logic                             code_err,
    output logic                             clean,
    output logic [ROW_BITS-1:0]              fix_addr,
    output logic [BYTE_W-1:0]                fix_mask
);
    localparam int PAIRS    = ROW_BITS + COL_BITS;
    localparam int ECC_BITS = 2 * PAIRS;

    logic [PAIRS-1:0]    pair_one;
    logic [COL_BITS-1:0] bitpos;

    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
        assign pair_one[p] = syn[2*p] ^ syn[2*p+1];
    end

    for (genvar j = 0; j < COL_BITS; j++) begin : g_col
        assign bitpos[j] = syn[2*j+1];
    end

    for (genvar k = 0; k < ROW_BITS; k++) begin : g_addr
        assign fix_addr[k] = syn[2*COL_BITS+2*k+1];
    end

    assign correctable = &pair_one;
    assign clean       = (syn == '0);
    assign code_err    = !clean && ((syn & (syn - ECC_BITS'(1))) == '0);
    assign fix_mask    = BYTE_W'(1) << bitpos;

endmodule

// File: rtl/nand_secded_engine.sv
module nand_secded_engine
    import secded_pkg::*;
#(
    parameter int SECTOR_BYTES = 512
) (
    input  logic                                          clk,
    input  logic                                          rst,
    input  logic                                          ecc_en,
    input  logic                                          rd_mode,
    input  logic                                          in_vld,
    input  logic [7:0]                                    in_byte,
    input  logic [2*($clog2(SECTOR_BYTES)+COL_BITS)-1:0]  stored_ecc,
    output logic                                          ecc_vld,
    output logic [2*($clog2(SECTOR_BYTES)+COL_BITS)-1:0]  ecc_code,
    output logic                                          fix_we,
    output logic [$clog2(SECTOR_BYTES)-1:0]               fix_addr,
    output logic [7:0]                                    fix_mask,
    output logic [3:0]                                    status
);
    localparam int ROW_BITS = $clog2(SECTOR_BYTES);
    localparam int ECC_BITS = 2 * (ROW_BITS + COL_BITS);

    logic [ECC_BITS-1:0] acc, stored_q, syn;
    logic                done, mode_q;
    logic                correctable, code_err, clean;
    sec_status_t         stat_q, stat_d;

    secded_accum #(.SECTOR_BYTES(SECTOR_BYTES)) u_accum (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (in_vld),
        .in_byte (in_byte),
        .acc     (acc),
        .done    (done)
    );

    // Stored code and mode are captured with every byte; the last byte's copy is used.
    always_ff @(posedge clk) begin
        if (rst) begin
            stored_q <= '0;
            mode_q   <= 1'b0;
        end else if (in_vld) begin
            stored_q <= stored_ecc;
            mode_q   <= rd_mode;
        end
    end

    assign syn = acc ^ stored_q;

    secded_decode #(.ROW_BITS(ROW_BITS)) u_decode (
        .syn         (syn),
        .correctable (correctable),
        .code_err    (code_err),
        .clean       (clean),
        .fix_addr    (fix_addr),
        .fix_mask    (fix_mask)
    );

    assign ecc_code = acc;
    assign ecc_vld  = done && ecc_en && !mode_q;
    assign fix_we   = done && ecc_en && mode_q && correctable;

    always_comb begin
        stat_d = stat_q;
        if (!ecc_en) begin
            stat_d = '{spare: SEC_CLEAN, main: SEC_CLEAN};
        end else if (done && mode_q) begin
            if (correctable)             stat_d.main = SEC_FIXED;
            else if (clean || code_err)  stat_d.main = SEC_CLEAN;
            else                         stat_d.main = SEC_FAIL;
            stat_d.spare = code_err ? SEC_FIXED : SEC_CLEAN;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) stat_q <= '{spare: SEC_CLEAN, main: SEC_CLEAN};
        else     stat_q <= stat_d;
    end

    assign status = stat_q;

endmodule

// File: rtl/nand_secded_checker.sv
module nand_secded_checker (
    input logic       clk,
    input logic       rst,
    input logic       ecc_en,
    input logic       ecc_vld,
    input logic       fix_we,
    input logic [7:0] fix_mask,
    input logic [3:0] status
);

    AST_FIX_MASK_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        fix_we |-> ($countones(fix_mask) == 1)); // R3

    AST_FIX_SETS_REPAIRED: assert property (@(posedge clk) disable iff (rst)
        fix_we |=> (status[1:0] == 2'd1)); // R3

    AST_STATUS_CODES_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (status[1:0] != 2'd3) && (status[3:2] != 2'd3)); // R7

    AST_WRITE_KEEPS_STATUS: assert property (@(posedge clk) disable iff (rst)
        ecc_vld |=> $stable(status)); // R2

    AST_PATHS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(fix_we && ecc_vld)); // R2

    AST_OFF_NO_ACTION: assert property (@(posedge clk) disable iff (rst)
        !ecc_en |-> (!fix_we && !ecc_vld)); // R8

    AST_OFF_STATUS_ZERO: assert property (@(posedge clk) disable iff (rst)
        !ecc_en |=> (status == 4'd0)); // R8

endmodule

bind nand_secded_engine nand_secded_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .ecc_en   (ecc_en),
    .ecc_vld  (ecc_vld),
    .fix_we   (fix_we),
    .fix_mask (fix_mask),
    .status   (status)
);

// File: tb/nand_secded_engine_bench.sv
module nand_secded_engine_bench;

    localparam int SEC = 32;
    localparam int RB  = 5;
    localparam int EB  = 2 * (RB + 3);

    logic          clk = 1'b0;
    logic          rst;
    logic          ecc_en;
    logic          rd_mode;
    logic          in_vld;
    logic [7:0]    in_byte;
    logic [EB-1:0] stored_ecc;
    logic          ecc_vld;
    logic [EB-1:0] ecc_code;
    logic          fix_we;
    logic [RB-1:0] fix_addr;
    logic [7:0]    fix_mask;
    logic [3:0]    status;

    always #5 clk = ~clk;

    nand_secded_engine #(.SECTOR_BYTES(SEC)) u_nand_secded_engine (
        .clk        (clk),
        .rst        (rst),
        .ecc_en     (ecc_en),
        .rd_mode    (rd_mode),
        .in_vld     (in_vld),
        .in_byte    (in_byte),
        .stored_ecc (stored_ecc),
        .ecc_vld    (ecc_vld),
        .ecc_code   (ecc_code),
        .fix_we     (fix_we),
        .fix_addr   (fix_addr),
        .fix_mask   (fix_mask),
        .status     (status)
    );

    int n_tests = 0;
    int n_fail  = 0;

    logic [7:0]    gold [SEC];
    logic [7:0]    dat  [SEC];
    logic          s_fw, s_ev;
    logic [RB-1:0] s_fa;
    logic [7:0]    s_fm;
    logic [EB-1:0] s_code;
    logic [3:0]    s_st;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    // Expected code from the bit layout alone.
    function automatic logic [EB-1:0] code_of(input logic [7:0] m [SEC]);
        logic [EB-1:0] c;
        c = '0;
        for (int i = 0; i < SEC; i++) begin
            for (int b = 0; b < 8; b++) begin
                if (m[i][b]) begin
                    for (int j = 0; j < 3; j++) c[2*j + ((b >> j) & 1)] ^= 1'b1;
                    for (int k = 0; k < RB; k++) c[6 + 2*k + ((i >> k) & 1)] ^= 1'b1;
                end
            end
        end
        return c;
    endfunction

    function automatic bit dat_matches();
        for (int i = 0; i < SEC; i++) if (dat[i] != gold[i]) return 1'b0;
        return 1'b1;
    endfunction

    task automatic fill(input int seed);
        for (int i = 0; i < SEC; i++) begin
            if (seed == 0)      gold[i] = 8'h00;
            else if (seed == 1) gold[i] = 8'hFF;
            else                gold[i] = 8'((i * 37) + (seed * 11) + (i >> 2) + (seed * i));
            dat[i] = gold[i];
        end
    endtask

    // Called at a negedge; returns at the negedge of the cycle after the last byte.
    task automatic send_dat();
        for (int i = 0; i < SEC; i++) begin
            in_vld  = 1'b1;
            in_byte = dat[i];
            @(negedge clk);
        end
        s_fw   = fix_we;
        s_fa   = fix_addr;
        s_fm   = fix_mask;
        s_ev   = ecc_vld;
        s_code = ecc_code;
    endtask

    task automatic read_sector(input logic [EB-1:0] stored);
        rd_mode    = 1'b1;
        stored_ecc = stored;
        send_dat();
        if (s_fw) dat[s_fa] = dat[s_fa] ^ s_fm;
        in_vld = 1'b0;
        @(negedge clk);
        s_st = status;
    endtask

    task automatic write_sector();
        rd_mode    = 1'b0;
        stored_ecc = '0;
        send_dat();
        in_vld = 1'b0;
        @(negedge clk);
        s_st = status;
    endtask

    initial begin
        logic [EB-1:0] exp_code, exp1, exp2, c1;
        logic          v1;
        logic [3:0]    st_before;

        rst = 1'b1; ecc_en = 1'b1; rd_mode = 1'b0; in_vld = 1'b0;
        in_byte = '0; stored_ecc = '0;
        repeat (3) @(negedge clk);
        chk(ecc_vld == 1'b0, "R9", "ecc_vld after reset", ecc_vld, 0);
        chk(fix_we == 1'b0, "R9", "fix_we after reset", fix_we, 0);
        chk(status == 4'd0, "R9", "status after reset", status, 0);
        rst = 1'b0;
        @(negedge clk);

        // Write path: code value and timing, status untouched
        for (int s = 0; s < 8; s++) begin
            fill(s);
            exp_code = code_of(dat);
            write_sector();
            chk(s_ev == 1'b1, "R2", "ecc_vld in cycle after last byte", s_ev, 1);
            chk(s_code == exp_code, "R1", "generated code", s_code, exp_code);
            chk(s_st == 4'd0, "R2", "status after write sector", s_st, 0);
        end

        // Back-to-back write sectors
        fill(20);
        exp1 = code_of(dat);
        rd_mode = 1'b0;
        send_dat();
        v1 = s_ev; c1 = s_code;
        fill(21);
        exp2 = code_of(dat);
        send_dat();
        in_vld = 1'b0;
        chk(v1 && c1 == exp1, "R10", "first back-to-back code", c1, exp1);
        chk(s_ev && s_code == exp2, "R10", "second back-to-back code", s_code, exp2);
        @(negedge clk);

        // Clean reads
        for (int s = 0; s < 4; s++) begin
            fill(s + 30);
            read_sector(code_of(gold));
            chk(s_fw == 1'b0, "R4", "no correction on clean sector", s_fw, 0);
            chk(s_st == 4'd0, "R4", "status on clean sector", s_st, 0);
        end

        // Every single data-bit error
        for (int i = 0; i < SEC; i++) begin
            for (int b = 0; b < 8; b++) begin
                fill(i + b + 2);
                dat[i][b] = ~dat[i][b];
                read_sector(code_of(gold));
                chk(s_fw && s_fa == RB'(i) && s_fm == 8'(1 << b), "R3",
                    "correction address/mask", {s_fw, s_fa, s_fm}, {1'b1, RB'(i), 8'(1 << b)});
                chk(dat_matches(), "R3", "buffer repaired", dat[i], gold[i]);
                chk(s_st == 4'b0001, "R7", "status main=repaired", s_st, 4'b0001);
            end
        end

        // Every single stored-code bit error
        for (int e = 0; e < EB; e++) begin
            fill(50);
            read_sector(code_of(gold) ^ (EB'(1) << e));
            chk(s_fw == 1'b0, "R5", "no correction on code error", s_fw, 0);
            chk(dat_matches(), "R5", "data untouched on code error", 0, 0);
            chk(s_st == 4'b0100, "R5", "status spare=1 main=0", s_st, 4'b0100);
        end

        // Double data-bit errors
        for (int t = 0; t < 64; t++) begin
            int i1, b1, i2, b2;
            i1 = t % SEC; b1 = t % 8;
            i2 = (t * 7 + 3) % SEC; b2 = (t * 3 + 1) % 8;
            if (i1 == i2 && b1 == b2) b2 = (b2 + 1) % 8;
            fill(t + 3);
            dat[i1][b1] = ~dat[i1][b1];
            dat[i2][b2] = ~dat[i2][b2];
            read_sector(code_of(gold));
            chk(s_fw == 1'b0, "R6", "no correction on double error", s_fw, 0);
            chk(s_st == 4'b0010, "R6", "status main=uncorrectable", s_st, 4'b0010);
        end

        // Status holds across a write sector, then a clean read clears it
        st_before = status;
        fill(7);
        write_sector();
        chk(s_st == st_before, "R7", "status held over write sector", s_st, st_before);
        fill(8);
        read_sector(code_of(gold));
        chk(s_st == 4'd0, "R7", "status replaced by next read", s_st, 0);

        // Disabled mode
        fill(9);
        dat[3][2] = ~dat[3][2];
        read_sector(code_of(gold));
        chk(s_st == 4'b0001, "R3", "enabled repair before disable", s_st, 4'b0001);
        fill(10);
        dat[4][1] = ~dat[4][1];
        dat[9][6] = ~dat[9][6];
        read_sector(code_of(gold));
        chk(s_st == 4'b0010, "R6", "uncorrectable before disable", s_st, 4'b0010);
        ecc_en = 1'b0;
        @(negedge clk);
        chk(status == 4'd0, "R8", "status cleared when disabled", status, 0);
        fill(11);
        dat[3][2] = ~dat[3][2];
        read_sector(code_of(gold));
        chk(s_fw == 1'b0, "R8", "no correction when disabled", s_fw, 0);
        chk(dat[3] == (gold[3] ^ 8'h04), "R8", "data passes unchanged", dat[3], gold[3] ^ 8'h04);
        chk(s_st == 4'd0, "R8", "status zero when disabled", s_st, 0);
        fill(12);
        write_sector();
        chk(s_ev == 1'b0, "R8", "no code when disabled", s_ev, 0);
        ecc_en = 1'b1;
        @(negedge clk);

        finish_run();
    end

endmodule